// File: doc/BRIEF.md
# Shared Operand Memory for a Multiply-Accumulate Engine

This block holds 1 KB of operand storage shared by a host processor and a multiply-accumulate engine. The host sees it as 1024 bytes. It can read and write them through a byte-wide port. The engine reads the same storage through a 16-bit read-only port, as two banks of 256 words. Bank X holds the first operand vector and bank Y holds the second. Operands are stored as two's-complement words. Each word is split across two bytes: the low byte sits at the even host offset and the high byte at the odd one.

The host builds a 24-bit address by placing a page byte above its 16-bit bus address. An access belongs to this memory only when two things are true. The top byte must equal the page value supplied on `host_page`. Bus address bits [15:10] must equal the window constant `WIN_BASE`. With the default of 6'h37, the window spans DC00h to DFFFh. Offsets 000h to 1FFh hold bank X and offsets 200h to 3FFh hold bank Y.

Both ports read synchronously with one cycle of latency. The two ports run fully in parallel. When an engine read and a host write reach the same word in one cycle, the engine receives the word as it was before the write.

Top module: `coef_dpram`

## Requirements
- R1: A host write (`host_cs`=1, `host_we`=1) that hits the window stores `host_wdata` at byte offset `host_addr[9:0]`. A later host read of that offset returns the byte on `host_rdata`, with `host_rvalid`=1, one clock edge after the read request is sampled.
- R2: A host access hits only when `host_addr[23:16]` equals `host_page` and `host_addr[15:10]` equals `WIN_BASE`. On a miss, a write changes no stored byte, and a read leaves `host_rvalid` at 0 and `host_rdata` at 0.
- R3: An engine read with `eng_bank`=0 (bank X) and index i returns, one edge later, a word built from host bytes 2i (bits [7:0]) and 2i+1 (bits [15:8]).
- R4: An engine read with `eng_bank`=1 (bank Y) and index i returns a word built from host bytes 512+2i (bits [7:0]) and 513+2i (bits [15:8]).
- R5: Writing only the odd byte of a word changes bits [15:8] of the engine word and leaves bits [7:0] unchanged.
- R6: While `eng_re` is 0, `eng_rdata` keeps its last value, whatever `eng_bank` and `eng_idx` do.
- R7: When a host write and an engine read hit the same word in the same cycle, the engine returns the old word. The next engine read of that word returns the new word.
- R8: After reset, `host_rvalid` is 0, `host_rdata` is 0 and `eng_rdata` is 0.
- R9: A host write and an engine read of different words in the same cycle both complete correctly.
- R10: A host write request never raises `host_rvalid` on the following edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_page | input | 8 | Page value compared with the top address byte |
| host_cs | input | 1 | Host access request |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 24 | Host address, page byte on top |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Host read byte, 0 when not valid |
| host_rvalid | output | 1 | Host read data valid |
| eng_re | input | 1 | Engine read enable |
| eng_bank | input | 1 | 0 = bank X, 1 = bank Y |
| eng_idx | input | 8 | Word index within the bank |
| eng_rdata | output | 16 | Engine read word |

## Verification
Every result in this block is due exactly one rising edge after the request is sampled. This covers host read data, the host valid flag and engine words. A miss or a write shows up as a low valid flag on that same edge. The bench drives each request on a falling edge and releases it on the next falling edge. It samples outputs on that second falling edge, half a cycle after the edge that produced them. For the hold case of R6, the bench waits two further cycles with the enable low before it compares. For the collision case of R7, the bench samples on the same edge and then issues a second read on the following cycle, so the old word and the new word are each checked in their own cycle.

// File: rtl/coef_ram_pkg.sv
package coef_ram_pkg;
  localparam int BYTE_W = 8;
  localparam logic BANK_X = 1'b0;
  localparam logic BANK_Y = 1'b1;
endpackage

// File: rtl/coef_host_decode.sv
module coef_host_decode #(
  parameter int PAGE_W  = 8,
  parameter int BUS_AW  = 16,
  parameter int OFF_W   = 10,
  parameter int WIN_W   = BUS_AW - OFF_W,
  parameter logic [WIN_W-1:0] WIN_BASE = '0
) (
  input  logic [PAGE_W+BUS_AW-1:0] addr,
  input  logic [PAGE_W-1:0]        page,
  input  logic                     cs,
  input  logic                     we,
  output logic                     rd_hit,
  output logic                     wr_hit,
  output logic [OFF_W-2:0]         word,
  output logic                     lane
);
  logic page_ok;
  logic win_ok;

  always_comb begin
    page_ok = (addr[PAGE_W+BUS_AW-1:BUS_AW] == page);
    win_ok  = (addr[BUS_AW-1:OFF_W] == WIN_BASE);
    rd_hit  = cs && !we && page_ok && win_ok;
    wr_hit  = cs &&  we && page_ok && win_ok;
    // bit 0 picks the byte lane; the bits above it form the word (bank on top)
    word    = addr[OFF_W-1:1];
    lane    = addr[0];
  end
endmodule

// File: rtl/coef_lane_ram.sv
module coef_lane_ram #(
  parameter int DW = 8,
  parameter int AW = 9,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          ha_en,
  input  logic [AW-1:0] ha_addr,
  output logic [DW-1:0] ha_q,
  input  logic          eb_en,
  input  logic [AW-1:0] eb_addr,
  output logic [DW-1:0] eb_q
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ha_d;
  logic [DW-1:0] eb_d;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  // reads take the array value from before this edge's write: old data on collision
  always_comb begin
    ha_d = ha_en ? mem[ha_addr] : ha_q;
    eb_d = eb_en ? mem[eb_addr] : eb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ha_q <= '0;
      eb_q <= '0;
    end else begin
      ha_q <= ha_d;
      eb_q <= eb_d;
    end
  end
endmodule

// File: rtl/coef_dpram.sv
module coef_dpram
  import coef_ram_pkg::*;
#(
  parameter int PAGE_W    = 8,
  parameter int BUS_AW    = 16,
  parameter int RAM_BYTES = 1024,
  parameter int ENG_W     = 16,
  parameter logic [BUS_AW-$clog2(RAM_BYTES)-1:0] WIN_BASE = 6'h37,
  localparam int OFF_W = $clog2(RAM_BYTES),
  localparam int WORD_AW = OFF_W - 1,
  localparam int IDX_W = WORD_AW - 1,
  localparam int LANES = ENG_W / BYTE_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [PAGE_W-1:0]        host_page,
  input  logic                     host_cs,
  input  logic                     host_we,
  input  logic [PAGE_W+BUS_AW-1:0] host_addr,
  input  logic [BYTE_W-1:0]        host_wdata,
  output logic [BYTE_W-1:0]        host_rdata,
  output logic                     host_rvalid,
  input  logic                     eng_re,
  input  logic                     eng_bank,
  input  logic [IDX_W-1:0]         eng_idx,
  output logic [ENG_W-1:0]         eng_rdata
);
  logic               rd_hit;
  logic               wr_hit;
  logic [WORD_AW-1:0] hword;
  logic               hlane;
  logic [WORD_AW-1:0] eword;
  logic [BYTE_W-1:0]  hq [LANES];
  logic               rvalid_d, rvalid_q;
  logic               lane_d, lane_q;

  coef_host_decode #(
    .PAGE_W(PAGE_W), .BUS_AW(BUS_AW), .OFF_W(OFF_W), .WIN_BASE(WIN_BASE)
  ) u_dec (
    .addr(host_addr), .page(host_page), .cs(host_cs), .we(host_we),
    .rd_hit(rd_hit), .wr_hit(wr_hit), .word(hword), .lane(hlane)
  );

  assign eword = {eng_bank, eng_idx};

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    coef_lane_ram #(.DW(BYTE_W), .AW(WORD_AW)) u_ram (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_hit && (hlane == g[0])),
      .wr_addr(hword), .wr_data(host_wdata),
      .ha_en(rd_hit), .ha_addr(hword), .ha_q(hq[g]),
      .eb_en(eng_re), .eb_addr(eword), .eb_q(eng_rdata[g*BYTE_W +: BYTE_W])
    );
  end

  always_comb begin
    rvalid_d = rd_hit;
    lane_d   = rd_hit ? hlane : lane_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      lane_q   <= 1'b0;
    end else begin
      rvalid_q <= rvalid_d;
      lane_q   <= lane_d;
    end
  end

  assign host_rvalid = rvalid_q;
  assign host_rdata  = rvalid_q ? hq[lane_q] : '0;
endmodule

// File: rtl/coef_dpram_chk.sv
module coef_dpram_chk #(
  parameter int PAGE_W    = 8,
  parameter int BUS_AW    = 16,
  parameter int RAM_BYTES = 1024,
  parameter int ENG_W     = 16,
  parameter logic [BUS_AW-$clog2(RAM_BYTES)-1:0] WIN_BASE = 6'h37,
  localparam int OFF_W = $clog2(RAM_BYTES),
  localparam int IDX_W = OFF_W - 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [PAGE_W-1:0]        host_page,
  input logic                     host_cs,
  input logic                     host_we,
  input logic [PAGE_W+BUS_AW-1:0] host_addr,
  input logic [7:0]               host_wdata,
  input logic [7:0]               host_rdata,
  input logic                     host_rvalid,
  input logic                     eng_re,
  input logic                     eng_bank,
  input logic [IDX_W-1:0]         eng_idx,
  input logic [ENG_W-1:0]         eng_rdata
);
  logic run_q;
  logic req_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= 1'b1;
  end

  assign req_hit = host_cs && !host_we &&
                   (host_addr[PAGE_W+BUS_AW-1:BUS_AW] == host_page) &&
                   (host_addr[BUS_AW-1:OFF_W] == WIN_BASE);

  // R1 / R2: valid only follows a read that hit the window
  a_r2_valid_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && host_rvalid |-> $past(req_hit));

  // R1: a read that hit the window yields valid on the next edge
  a_r1_read_latency: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit |=> host_rvalid);

  // R2: read data stays quiet when not valid
  a_r2_quiet_bus: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rvalid |-> host_rdata == 8'h00);

  // R10: a write request never produces read valid
  a_r10_write_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    host_cs && host_we |=> !host_rvalid);

  // R6: engine word holds while its enable is low
  a_r6_eng_hold: assert property (@(posedge clk) disable iff (!rst_n)
    run_q && !eng_re |=> $stable(eng_rdata));
endmodule

bind coef_dpram coef_dpram_chk #(
  .PAGE_W(PAGE_W), .BUS_AW(BUS_AW), .RAM_BYTES(RAM_BYTES),
  .ENG_W(ENG_W), .WIN_BASE(WIN_BASE)
) u_chk (.*);

// File: tb/coef_dpram_test.sv
module coef_dpram_test;
  import coef_ram_pkg::*;

  localparam logic [7:0] PAGE = 8'h80;
  localparam logic [5:0] WIN  = 6'h37;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  host_page;
  logic        host_cs;
  logic        host_we;
  logic [23:0] host_addr;
  logic [7:0]  host_wdata;
  logic [7:0]  host_rdata;
  logic        host_rvalid;
  logic        eng_re;
  logic        eng_bank;
  logic [7:0]  eng_idx;
  logic [15:0] eng_rdata;

  logic [7:0]  model [1024];
  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  coef_dpram uut (
    .clk(clk), .rst_n(rst_n), .host_page(host_page), .host_cs(host_cs),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid), .eng_re(eng_re),
    .eng_bank(eng_bank), .eng_idx(eng_idx), .eng_rdata(eng_rdata)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] in_win(input logic [9:0] off);
    return {PAGE, WIN, off};
  endfunction

  function automatic logic [15:0] exp_word(input logic bank, input logic [7:0] idx);
    int base;
    base = (bank ? 512 : 0) + 2 * int'(idx);
    return {model[base+1], model[base]};
  endfunction

  task automatic host_wr(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_cs = 1'b0; host_we = 1'b0;
  endtask

  task automatic host_rd(input logic [23:0] a, output logic [7:0] d, output logic v);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b0; host_addr = a;
    @(negedge clk);
    d = host_rdata; v = host_rvalid;
    host_cs = 1'b0;
  endtask

  task automatic eng_rd(input logic bank, input logic [7:0] idx, output logic [15:0] w);
    @(negedge clk);
    eng_re = 1'b1; eng_bank = bank; eng_idx = idx;
    @(negedge clk);
    w = eng_rdata;
    eng_re = 1'b0;
  endtask

  task automatic t_reset;
    check("R8 host_rvalid", host_rvalid, 0);
    check("R8 host_rdata", host_rdata, 0);
    check("R8 eng_rdata", eng_rdata, 0);
  endtask

  task automatic t_fill_and_readback;
    logic [7:0] d;
    logic v;
    for (int i = 0; i < 1024; i++) begin
      model[i] = 8'(i * 37 + 5);
      host_wr(in_win(10'(i)), model[i]);
    end
    for (int k = 0; k < 4; k++) begin
      int off;
      off = (k == 0) ? 0 : (k == 1) ? 511 : (k == 2) ? 512 : 1023;
      host_rd(in_win(10'(off)), d, v);
      check("R1 host valid", v, 1);
      check("R1 host data", d, model[off]);
    end
  endtask

  task automatic t_miss;
    logic [7:0] d;
    logic v;
    host_wr({PAGE ^ 8'h01, WIN, 10'd40}, 8'hA5);
    host_wr({PAGE, WIN ^ 6'h01, 10'd41}, 8'h5A);
    host_rd(in_win(10'd40), d, v);
    check("R2 wrong page write ignored", d, model[40]);
    host_rd(in_win(10'd41), d, v);
    check("R2 wrong window write ignored", d, model[41]);
    host_rd({PAGE ^ 8'h10, WIN, 10'd40}, d, v);
    check("R2 miss read valid", v, 0);
    check("R2 miss read data", d, 0);
    host_rd({PAGE, 6'h36, 10'd40}, d, v);
    check("R2 window miss valid", v, 0);
  endtask

  task automatic t_banks;
    logic [15:0] w;
    eng_rd(BANK_X, 8'd0, w);   check("R3 bank X idx 0", w, exp_word(BANK_X, 8'd0));
    eng_rd(BANK_X, 8'd255, w); check("R3 bank X idx 255", w, exp_word(BANK_X, 8'd255));
    eng_rd(BANK_X, 8'd77, w);  check("R3 bank X idx 77", w, exp_word(BANK_X, 8'd77));
    eng_rd(BANK_Y, 8'd0, w);   check("R4 bank Y idx 0", w, exp_word(BANK_Y, 8'd0));
    eng_rd(BANK_Y, 8'd255, w); check("R4 bank Y idx 255", w, exp_word(BANK_Y, 8'd255));
  endtask

  task automatic t_odd_lane;
    logic [15:0] w;
    logic [7:0] lo;
    lo = model[512 + 6];
    model[512 + 7] = 8'hC3;
    host_wr(in_win(10'd519), 8'hC3);
    eng_rd(BANK_Y, 8'd3, w);
    check("R5 high byte updated", w[15:8], 8'hC3);
    check("R5 low byte unchanged", w[7:0], lo);
  endtask

  task automatic t_hold;
    logic [15:0] w;
    eng_rd(BANK_X, 8'd9, w);
    @(negedge clk);
    eng_bank = BANK_Y; eng_idx = 8'd200;
    @(negedge clk);
    @(negedge clk);
    check("R6 hold while disabled", eng_rdata, exp_word(BANK_X, 8'd9));
  endtask

  task automatic t_collide;
    logic [15:0] old_w;
    logic [15:0] w;
    old_w = exp_word(BANK_X, 8'd5);
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b1; host_addr = in_win(10'd10); host_wdata = ~model[10];
    eng_re = 1'b1; eng_bank = BANK_X; eng_idx = 8'd5;
    @(negedge clk);
    w = eng_rdata;
    host_cs = 1'b0; host_we = 1'b0; eng_re = 1'b0;
    model[10] = ~model[10];
    check("R7 collision returns old word", w, old_w);
    eng_rd(BANK_X, 8'd5, w);
    check("R7 next read returns new word", w, exp_word(BANK_X, 8'd5));
  endtask

  task automatic t_parallel;
    logic [15:0] w;
    logic [7:0] d;
    logic v;
    @(negedge clk);
    host_cs = 1'b1; host_we = 1'b1; host_addr = in_win(10'd21); host_wdata = 8'h7E;
    eng_re = 1'b1; eng_bank = BANK_Y; eng_idx = 8'd10;
    @(negedge clk);
    w = eng_rdata;
    check("R10 no valid after write", host_rvalid, 0);
    host_cs = 1'b0; host_we = 1'b0; eng_re = 1'b0;
    model[21] = 8'h7E;
    check("R9 engine read alongside write", w, exp_word(BANK_Y, 8'd10));
    host_rd(in_win(10'd21), d, v);
    check("R9 host write alongside read", d, 8'h7E);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_page = PAGE; host_cs = 1'b0; host_we = 1'b0; host_addr = '0; host_wdata = '0;
    eng_re = 1'b0; eng_bank = 1'b0; eng_idx = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    t_fill_and_readback;
    t_miss;
    t_banks;
    t_odd_lane;
    t_hold;
    t_collide;
    t_parallel;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule